// File: doc/BRIEF.md
# Interrupt Latch and Mask Controller

This controller gathers 32 interrupt sources into a pending register and offers the most urgent serviceable one to a processor. Some sources are single-cycle pulses from logic on the same clock. Others are asynchronous external request lines, which are synchronized and captured on their rising edge. A captured event stays pending until one of two things clears it: the processor acknowledges it, or software rewrites the pending register.

Service needs three conditions at once. The source must be pending. Its enable bit in the mask register must be set. The global enable in the mode register must be set. A masked source, or any source while the global enable is clear, still records its event, so nothing is lost. Bit 1 is the reset source. It is always unmasked, and software writes cannot change its pending bit. When several sources are serviceable, the lowest-numbered one is presented as the vector.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads 0x0000_0002 (only the reset source enabled), the mode register reads 0 and `irq_req_o` is low.
- R2: External line k sets pending bit EXT_BASE+k (bits 5 to 8 by default) on the third rising clock edge after the line goes high. A line held high latches once only. A high pulse of one cycle latches exactly once.
- R3: A high `int_evt_i` bit sets the matching pending bit at the next clock edge. This holds whatever the mask and the global enable are.
- R4: A pending source whose mask bit is 0 is not serviced. It stays pending and is requested as soon as its mask bit is set to 1.
- R5: `irq_req_o` is high only while bit 12 of the mode register is 1. Clearing bit 12 does not stop events from latching.
- R6: `irq_vec_o` is the lowest index whose pending bit and mask bit are both 1. `irq_req_o` is high when such an index exists and the enable is set.
- R7: `irq_ack_i` sampled high while `irq_req_o` is high clears the pending bit at `irq_vec_o`. An event on that same bit in the same cycle leaves the bit set.
- R8: A write with select 0 loads the pending register from `reg_wdata_i`. Bit 1 keeps its old value. Events in the same cycle still set their bits.
- R9: Mask bit 1 always reads 1, and writes cannot clear it, so a pending reset source is requested whatever mask value was written.
- R10: The read select chooses what `reg_rdata_o` shows, combinationally. Select 0 is pending, 1 is mask, 2 is mode (only bit 12 can be nonzero) and 3 reads 0. A write stores `reg_wdata_i` into the register selected in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | N_EXT | Asynchronous external request lines |
| int_evt_i | input | N_SRC | Synchronous event pulses, one per pending bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 pending, 1 mask, 2 mode |
| reg_wdata_i | input | N_SRC | Write data |
| reg_rdata_o | output | N_SRC | Read data of the selected register |
| irq_req_o | output | 1 | Interrupt request to the processor |
| irq_vec_o | output | VEC_W | Index of the presented source |
| irq_ack_i | input | 1 | Acknowledge of the presented source |

## Verification
The bench uses the default parameters: 32 sources, 4 external lines on bits 5 to 8, the reset source on bit 1 and the enable on mode bit 12. These values let one run reach several cases. Internal pulses and external edges can land on the same bit. Writes can try to clear the protected reset bit while it is pending. Acknowledges can coincide with a fresh event on the served bit. The enable bit's position in a wide mode word is also tested, by writes that set every other bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_MASK = 2'd1,
    SEL_MODE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_ext_sync.sv
module irq_ext_sync #(
  parameter int N_LINES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] rise_o
);
  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= line_i[k];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[k] = s2_q & ~s3_q;

    assert_single_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[k] |=> !rise_o[k]);
  end
endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs
  import irq_pkg::*;
#(
  parameter int N_SRC   = 32,
  parameter int RST_BIT = 1,
  parameter int EN_BIT  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] ev_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             en_o
);
  localparam logic [N_SRC-1:0] RST_ONE = N_SRC'(1) << RST_BIT;

  reg_sel_e         sel;
  logic [N_SRC-1:0] pend_q, pend_d, mask_q;
  logic             en_q;

  assign sel = reg_sel_e'(sel_i);

  always_comb begin
    pend_d = pend_q;
    if (we_i && sel == SEL_PEND) pend_d = (wdata_i & ~RST_ONE) | (pend_q & RST_ONE);
    pend_d = (pend_d & ~ack_clr_i) | ev_i;  // events win
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (we_i && sel == SEL_MASK) mask_q <= wdata_i;
      if (we_i && sel == SEL_MODE) en_q <= wdata_i[EN_BIT];
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q | RST_ONE;
  assign en_o   = en_q;

  assert_event_latched_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((pend_q & $past(ev_i)) == $past(ev_i)));

  assert_rst_bit_protect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_PEND && !ev_i[RST_BIT] && !ack_clr_i[RST_BIT])
    |=> pend_q[RST_BIT] == $past(pend_q[RST_BIT]));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC = 32,
  parameter int VEC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [VEC_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = VEC_W'(i);  // lowest index wins
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int N_EXT    = 4,
  parameter int EXT_BASE = 5,
  parameter int RST_BIT  = 1,
  parameter int EN_BIT   = 12,
  parameter int VEC_W    = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic [N_SRC-1:0] int_evt_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [N_SRC-1:0] reg_wdata_i,
  output logic [N_SRC-1:0] reg_rdata_o,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  input  logic             irq_ack_i
);
  logic [N_EXT-1:0] rise;
  logic [N_SRC-1:0] ext_ev, ev, ack_clr, pend, mask, serv;
  logic             en, any;

  irq_ext_sync #(.N_LINES(N_EXT)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(ext_irq_i),
    .rise_o(rise)
  );

  always_comb begin
    ext_ev = '0;
    for (int k = 0; k < N_EXT; k++) ext_ev[EXT_BASE+k] = rise[k];
  end
  assign ev = int_evt_i | ext_ev;

  assign ack_clr = (irq_ack_i && irq_req_o) ? (N_SRC'(1) << irq_vec_o) : '0;

  irq_pend_regs #(.N_SRC(N_SRC), .RST_BIT(RST_BIT), .EN_BIT(EN_BIT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .ack_clr_i(ack_clr),
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .pend_o   (pend),
    .mask_o   (mask),
    .en_o     (en)
  );

  assign serv = pend & mask;

  irq_prio_enc #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_prio (
    .req_i(serv),
    .any_o(any),
    .idx_o(irq_vec_o)
  );

  assign irq_req_o = any & en;

  always_comb begin
    unique case (reg_sel_e'(reg_sel_i))
      SEL_PEND: reg_rdata_o = pend;
      SEL_MASK: reg_rdata_o = mask;
      SEL_MODE: reg_rdata_o = N_SRC'(en) << EN_BIT;
      default:  reg_rdata_o = '0;
    endcase
  end

  assert_req_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> en);

  assert_vec_serviceable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (pend[irq_vec_o] && mask[irq_vec_o]));

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o && !ev[irq_vec_o] && !(reg_we_i && reg_sel_i == 2'd0))
    |=> !pend[$past(irq_vec_o)]);
endmodule

// File: tb/tb_irq_latch_ctrl.sv
`timescale 1ns/1ps
module tb_irq_latch_ctrl;
  localparam int NS = 32, NE = 4, EB = 5, RB = 1, EN = 12, VW = 5;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] ext = '0;
  logic [NS-1:0] evt = '0, wdata = '0, rdata;
  logic          we = 1'b0, ack = 1'b0, req;
  logic [1:0]    sel = 2'd0;
  logic [VW-1:0] vec;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_latch_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext), .int_evt_i(evt),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack)
  );

  // behavioural reference
  logic [NS-1:0] m_pend, m_mask;
  logic          m_en;
  logic [NE-1:0] m_s1, m_s2, m_s3;

  function automatic int m_idx(input logic [NS-1:0] p, input logic [NS-1:0] m);
    for (int i = 0; i < NS; i++) if (p[i] && (m[i] || i == RB)) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '0; m_en = 0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
    end else begin
      logic [NS-1:0] e, np;
      int w;
      e = evt;
      for (int k = 0; k < NE; k++) if (m_s2[k] && !m_s3[k]) e[EB+k] = 1'b1;
      w = m_idx(m_pend, m_mask);
      np = m_pend;
      if (we && sel == 2'd0) begin
        np = wdata;
        np[RB] = m_pend[RB];
      end
      if (ack && m_en && w >= 0) np[w] = 1'b0;
      np = np | e;
      m_pend = np;
      if (we && sel == 2'd1) m_mask = wdata;
      if (we && sel == 2'd2) m_en = wdata[EN];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NS-1:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return m_pend;
      2'd1: return m_mask | (NS'(1) << RB);
      2'd2: return NS'(m_en) << EN;
      default: return '0;
    endcase
  endfunction

  task automatic compare();
    int w;
    w = m_idx(m_pend, m_mask);
    chk(req === (m_en && w >= 0), "R5 req", req, m_en && w >= 0);
    if (m_en && w >= 0) chk(vec === VW'(w), "R6 vec", vec, w);
    chk(rdata === m_read(sel), "R10 rdata", rdata, m_read(sel));
  endtask

  task automatic tick();
    @(posedge clk); #1;
    compare();
  endtask

  task automatic idle();
    we = 0; evt = '0; ack = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [NS-1:0] d);
    we = 1; sel = s; wdata = d; tick(); we = 0; sel = 2'd0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [NS-1:0] exp, input string tag);
    sel = s; #0.5;
    chk(rdata === exp, tag, rdata, exp);
    sel = 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #0.5;
    // R1 reset state
    rd(2'd0, 32'h0, "R1 pend");
    rd(2'd1, 32'h2, "R1 mask");
    rd(2'd2, 32'h0, "R1 mode");
    chk(req === 1'b0, "R1 req", req, 0);
    tick();

    // R3 latch while disabled and masked, R5 no request
    evt = 32'h0010_0000; tick(); idle();
    rd(2'd0, 32'h0010_0000, "R3 latched while masked");
    chk(req === 1'b0, "R5 no req while disabled", req, 0);
    wr(2'd1, 32'hFFFF_FFFF);
    chk(req === 1'b0, "R5 still disabled", req, 0);
    wr(2'd2, 32'hFFFF_EFFF);
    rd(2'd2, 32'h0, "R10 mode only enable bit");
    wr(2'd2, 32'h0000_1000);
    chk(req === 1'b1 && vec === 5'd20, "R5 enable requests", vec, 20);

    // R6 priority, R7 ack
    evt = 32'h0000_0208; tick(); idle();
    chk(vec === 5'd3, "R6 lowest wins", vec, 3);
    ack = 1; tick(); ack = 0;
    chk(vec === 5'd9, "R7 ack cleared 3", vec, 9);
    ack = 1; evt = 32'h0000_0200; tick(); idle();
    chk(vec === 5'd9, "R7 event beats ack", vec, 9);
    ack = 1; tick(); ack = 0;
    ack = 1; tick(); ack = 0;
    chk(req === 1'b0, "R7 all served", req, 0);

    // R2 external edge, held level
    ext[2] = 1; tick(); tick();
    chk(req === 1'b0, "R2 not yet latched", req, 0);
    tick();
    chk(req === 1'b1 && vec === 5'(EB + 2), "R2 latched third edge", vec, EB + 2);
    ack = 1; tick(); ack = 0;
    repeat (5) tick();
    chk(req === 1'b0, "R2 held line latches once", req, 0);
    ext[2] = 0; repeat (3) tick();
    ext[0] = 1; tick(); ext[0] = 0;
    repeat (4) tick();
    chk(req === 1'b1 && vec === 5'(EB), "R2 glitch latched", vec, EB);
    ack = 1; tick(); ack = 0;
    repeat (3) tick();
    chk(req === 1'b0, "R2 glitch once", req, 0);

    // R4 masked pending kept
    wr(2'd1, 32'hFFFF_FBFF);
    evt = 32'h0000_0400; tick(); idle();
    chk(req === 1'b0, "R4 masked no req", req, 0);
    rd(2'd0, 32'h0000_0400, "R4 still pending");
    wr(2'd1, 32'hFFFF_FFFF);
    chk(req === 1'b1 && vec === 5'd10, "R4 served on unmask", vec, 10);

    // R8 software write, reset bit protected
    wr(2'd0, 32'h0000_0000);
    chk(req === 1'b0, "R8 write clears", req, 0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'hFFFF_FFFD, "R8 bit1 not set by write");
    wr(2'd0, 32'h0);
    evt = 32'h0000_0002; tick(); idle();
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h0000_0002, "R8 bit1 not cleared by write");

    // R9 reset source unmaskable
    wr(2'd1, 32'h0);
    rd(2'd1, 32'h0000_0002, "R9 mask bit1 reads 1");
    chk(req === 1'b1 && vec === 5'd1, "R9 reset source served", vec, 1);
    ack = 1; tick(); ack = 0;
    rd(2'd3, 32'h0, "R10 select 3 reads 0");

    repeat (4) tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule